// File: doc/BRIEF.md
# Run-time SDRAM Data Width Adapter

This block joins a fixed 32-bit application data port to an SDRAM data path whose width (8, 16 or 32 bits) is picked at run time by a 2-bit select input. On the write side it cuts each application word and its four active-low byte enables into one, two or four memory beats. It asks the application for a fresh word only once the last beat of the current word has been taken by the memory side. On the read side it gathers narrow memory beats back into 32-bit words and strobes them to the application.

The transfer controller beside it marks the start and the end of every burst and says when a write beat is taken or a read beat arrives. The adapter turns those marks into word-level "next word" and "last word" flags for the application. All outputs are combinational functions of the current beat and a small amount of state, so no mode adds latency. Narrow beats always use the low lanes of the memory data bus.

Top module: `sdram_width_adapter`

## Requirements
- R1: `width_sel` selects the memory width: 2'b00 is 32 bits (one beat per word), 2'b01 is 16 bits (two beats), and both 2'b10 and 2'b11 are 8 bits (four beats).
- R2: In 32-bit mode a taken write beat shows `app_wr_data` and `app_wr_be_n` unchanged on `mem_wr_data` and `mem_wr_be_n` in the same cycle, and `app_wr_next` is high in that cycle.
- R3: In 16-bit mode write beat 0 carries word bits [15:0] on `mem_wr_data[15:0]` and beat 1 carries bits [31:16]; `mem_wr_data[31:16]` is zero, `mem_wr_be_n[1:0]` carries the matching enable pair (bits [1:0], then [3:2]) and `mem_wr_be_n[3:2]` is 2'b11.
- R4: In 8-bit mode write beats carry bytes 0, 1, 2, 3 in that order on `mem_wr_data[7:0]`, the rest of the bus is zero, `mem_wr_be_n[0]` is the matching enable bit and `mem_wr_be_n[3:1]` is 3'b111.
- R5: `app_wr_next` is high only in a cycle where `wr_take` is high and the taken beat is the last beat of the word or the last beat of the burst.
- R6: `app_wr_last` is high exactly when `app_wr_next` is high and `wr_last` is high.
- R7: `wr_start` makes the beat taken in the same cycle beat 0 of a word, whatever beats were taken before.
- R8: In 32-bit mode each `rd_beat` shows `mem_rd_data` on `app_rd_data` with `app_rd_valid` high in the same cycle.
- R9: In 16-bit mode the first read beat of a word fills bits [15:0] and the second fills bits [31:16]; `app_rd_valid` rises in the cycle of the second beat.
- R10: In 8-bit mode read beats fill bytes 0 to 3 in order and `app_rd_valid` rises in the cycle of the fourth beat.
- R11: `rd_start` discards any partly packed word; the beat arriving with it becomes the low part of a new word.
- R12: A read burst ending (`rd_last`) partway through a word delivers that word in the same cycle with `app_rd_valid` high; lanes not yet filled read as zero.
- R13: `app_rd_last` is high only together with `app_rd_valid` on the beat that carries `rd_last`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_sel | input | 2 | Memory width select (see R1) |
| app_wr_data | input | 32 | Application write word |
| app_wr_be_n | input | 4 | Active-low byte enables of the write word |
| app_wr_next | output | 1 | Current write word consumed, present the next one |
| app_wr_last | output | 1 | Consumed word was the final one of the burst |
| wr_start | input | 1 | First write beat of a burst |
| wr_take | input | 1 | Memory side takes the current write beat |
| wr_last | input | 1 | Taken write beat is the final one of the burst |
| mem_wr_data | output | 32 | Write beat toward memory, narrow beats in low lanes |
| mem_wr_be_n | output | 4 | Active-low beat byte masks, unused lanes high |
| rd_start | input | 1 | First read beat of a burst |
| rd_beat | input | 1 | A read beat is present on `mem_rd_data` |
| rd_last | input | 1 | Present read beat is the final one of the burst |
| mem_rd_data | input | 32 | Read beat from memory, narrow beats in low lanes |
| app_rd_data | output | 32 | Packed read word |
| app_rd_valid | output | 1 | `app_rd_data` holds a complete or closing word |
| app_rd_last | output | 1 | Delivered word is the final one of the burst |

## Verification
Every result of this block is due in the very cycle of the beat that causes it: write slices, byte masks and the next/last flags follow the taken beat combinationally, and a packed read word appears together with its completing or closing beat. The bench therefore drives each beat shortly after a rising edge, queues the result that beat should give, and a monitor takes it off the queue and compares at the following falling edge, before the state registers move. Idle cycles between bursts are queued as well, so a flag that fires one beat early or late meets an expectation of zero.

// File: rtl/sdram_width_pkg.sv
package sdram_width_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_HALF = 2'd1,
        MODE_BYTE = 2'd2
    } mem_mode_e;

    function automatic mem_mode_e decode_mode(input logic [1:0] sel);
        if (sel[1])      return MODE_BYTE;
        else if (sel[0]) return MODE_HALF;
        else             return MODE_FULL;
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } wr_state_t;

endpackage

// File: rtl/sdram_beat_lane_map.sv
module sdram_beat_lane_map
    import sdram_width_pkg::*;
#(
    parameter int SLICE_W = LANE_W
) (
    input  logic [1:0]               width_sel,
    input  logic [IDX_W-1:0]         beat_idx,
    output logic [IDX_W-1:0]         last_idx,
    output logic [IDX_W-1:0]         lane_shift,
    output logic [LANES-1:0]         en_mask,
    output logic [SLICE_W*LANES-1:0] data_mask
);

    always_comb begin
        case (decode_mode(width_sel))
            MODE_HALF: begin
                last_idx   = IDX_W'(1);
                lane_shift = IDX_W'({beat_idx[0], 1'b0});
                en_mask    = LANES'(4'b0011);
            end
            MODE_BYTE: begin
                last_idx   = IDX_W'(LANES - 1);
                lane_shift = beat_idx;
                en_mask    = LANES'(4'b0001);
            end
            default: begin
                last_idx   = '0;
                lane_shift = '0;
                en_mask    = '1;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
        assign data_mask[g*SLICE_W +: SLICE_W] = {SLICE_W{en_mask[g]}};
    end

endmodule

// File: rtl/sdram_wr_split.sv
module sdram_wr_split
    import sdram_width_pkg::*;
#(
    parameter int SLICE_W = LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               width_sel,
    input  logic                     wr_start,
    input  logic                     wr_take,
    input  logic                     wr_end,
    input  logic [SLICE_W*LANES-1:0] word_in,
    input  logic [LANES-1:0]         word_be_n,
    output logic [SLICE_W*LANES-1:0] beat_data,
    output logic [LANES-1:0]         beat_be_n,
    output logic                     word_next,
    output logic                     word_last
);

    localparam int WW   = SLICE_W * LANES;
    localparam int SH_W = $clog2(WW);

    wr_state_t          st_q, st_d;
    logic [IDX_W-1:0]   eff_idx;
    logic [IDX_W-1:0]   last_idx;
    logic [IDX_W-1:0]   lane_shift;
    logic [LANES-1:0]   en_mask;
    logic [WW-1:0]      data_mask;
    logic [SH_W-1:0]    shift_bits;
    logic               word_done;

    sdram_beat_lane_map #(.SLICE_W(SLICE_W)) u_map (
        .width_sel  (width_sel),
        .beat_idx   (eff_idx),
        .last_idx   (last_idx),
        .lane_shift (lane_shift),
        .en_mask    (en_mask),
        .data_mask  (data_mask)
    );

    always_comb begin
        eff_idx    = wr_start ? '0 : st_q.idx;
        shift_bits = SH_W'(int'(lane_shift) * SLICE_W);
        word_done  = wr_take && ((eff_idx == last_idx) || wr_end);
        st_d       = st_q;
        if (wr_take) begin
            st_d.idx = word_done ? '0 : eff_idx + IDX_W'(1);
        end else if (wr_start) begin
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_data = (word_in >> shift_bits) & data_mask;
    assign beat_be_n = (word_be_n >> lane_shift) | ~en_mask;
    assign word_next = word_done;
    assign word_last = word_done && wr_end;

endmodule

// File: rtl/sdram_rd_pack.sv
module sdram_rd_pack
    import sdram_width_pkg::*;
#(
    parameter int SLICE_W = LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               width_sel,
    input  logic                     rd_start,
    input  logic                     beat_valid,
    input  logic                     rd_end,
    input  logic [SLICE_W*LANES-1:0] beat_in,
    output logic [SLICE_W*LANES-1:0] word_out,
    output logic                     word_valid,
    output logic                     word_last
);

    localparam int WW   = SLICE_W * LANES;
    localparam int SH_W = $clog2(WW);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [WW-1:0]    acc;
    } rd_state_t;

    rd_state_t          st_q, st_d;
    logic [IDX_W-1:0]   eff_idx;
    logic [IDX_W-1:0]   last_idx;
    logic [IDX_W-1:0]   lane_shift;
    logic [LANES-1:0]   en_mask;
    logic [WW-1:0]      data_mask;
    logic [SH_W-1:0]    shift_bits;
    logic [WW-1:0]      base;
    logic [WW-1:0]      merged;
    logic               word_done;

    sdram_beat_lane_map #(.SLICE_W(SLICE_W)) u_map (
        .width_sel  (width_sel),
        .beat_idx   (eff_idx),
        .last_idx   (last_idx),
        .lane_shift (lane_shift),
        .en_mask    (en_mask),
        .data_mask  (data_mask)
    );

    always_comb begin
        eff_idx    = rd_start ? '0 : st_q.idx;
        shift_bits = SH_W'(int'(lane_shift) * SLICE_W);
        base       = (eff_idx == '0) ? '0 : st_q.acc;
        merged     = base | ((beat_in & data_mask) << shift_bits);
        word_done  = beat_valid && ((eff_idx == last_idx) || rd_end);
        st_d       = st_q;
        if (beat_valid) begin
            st_d.idx = word_done ? '0 : eff_idx + IDX_W'(1);
            st_d.acc = word_done ? '0 : merged;
        end else if (rd_start) begin
            st_d.idx = '0;
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_out   = merged;
    assign word_valid = word_done;
    assign word_last  = word_done && rd_end;

endmodule

// File: rtl/sdram_width_adapter.sv
module sdram_width_adapter
    import sdram_width_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width_sel,
    input  logic [WORD_W-1:0] app_wr_data,
    input  logic [LANES-1:0]  app_wr_be_n,
    output logic              app_wr_next,
    output logic              app_wr_last,
    input  logic              wr_start,
    input  logic              wr_take,
    input  logic              wr_last,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic [LANES-1:0]  mem_wr_be_n,
    input  logic              rd_start,
    input  logic              rd_beat,
    input  logic              rd_last,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic [WORD_W-1:0] app_rd_data,
    output logic              app_rd_valid,
    output logic              app_rd_last
);

    sdram_wr_split #(.SLICE_W(LANE_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .width_sel (width_sel),
        .wr_start  (wr_start),
        .wr_take   (wr_take),
        .wr_end    (wr_last),
        .word_in   (app_wr_data),
        .word_be_n (app_wr_be_n),
        .beat_data (mem_wr_data),
        .beat_be_n (mem_wr_be_n),
        .word_next (app_wr_next),
        .word_last (app_wr_last)
    );

    sdram_rd_pack #(.SLICE_W(LANE_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .width_sel  (width_sel),
        .rd_start   (rd_start),
        .beat_valid (rd_beat),
        .rd_end     (rd_last),
        .beat_in    (mem_rd_data),
        .word_out   (app_rd_data),
        .word_valid (app_rd_valid),
        .word_last  (app_rd_last)
    );

endmodule

// File: rtl/sdram_width_adapter_chk.sv
module sdram_width_adapter_chk
    import sdram_width_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        width_sel,
    input logic [LANES-1:0]  app_wr_be_n,
    input logic              app_wr_next,
    input logic              app_wr_last,
    input logic              wr_start,
    input logic              wr_take,
    input logic              wr_last,
    input logic [LANES-1:0]  mem_wr_be_n,
    input logic              rd_start,
    input logic              rd_beat,
    input logic              rd_last,
    input logic              app_rd_valid,
    input logic              app_rd_last
);

    logic [1:0] wcnt;
    logic [1:0] rcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            rcnt <= '0;
        end else begin
            if (wr_take)       wcnt <= app_wr_next ? 2'd0 : (wr_start ? 2'd1 : wcnt + 2'd1);
            else if (wr_start) wcnt <= 2'd0;
            if (rd_beat)       rcnt <= app_rd_valid ? 2'd0 : (rd_start ? 2'd1 : rcnt + 2'd1);
            else if (rd_start) rcnt <= 2'd0;
        end
    end

    p_full_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel == 2'b00 && wr_take) |-> (app_wr_next && mem_wr_be_n == app_wr_be_n));

    p_byte_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        width_sel[1] |-> (mem_wr_be_n[3:1] == 3'b111));

    p_next_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_next |-> wr_take);

    p_half_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel == 2'b01 && wr_take && !wr_start && wcnt == 2'd1) |-> app_wr_next);

    p_wr_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        app_wr_last |-> (app_wr_next && wr_last));

    p_byte_quad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel[1] && rd_beat && !rd_start && rcnt == 2'd3) |-> app_rd_valid);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel != 2'b00 && rd_start && rd_beat && !rd_last) |-> !app_rd_valid);

    p_rd_last_r13: assert property (@(posedge clk) disable iff (!rst_n)
        app_rd_last |-> (app_rd_valid && rd_last));

endmodule

bind sdram_width_adapter sdram_width_adapter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .width_sel    (width_sel),
    .app_wr_be_n  (app_wr_be_n),
    .app_wr_next  (app_wr_next),
    .app_wr_last  (app_wr_last),
    .wr_start     (wr_start),
    .wr_take      (wr_take),
    .wr_last      (wr_last),
    .mem_wr_be_n  (mem_wr_be_n),
    .rd_start     (rd_start),
    .rd_beat      (rd_beat),
    .rd_last      (rd_last),
    .app_rd_valid (app_rd_valid),
    .app_rd_last  (app_rd_last)
);

// File: tb/tb_sdram_width_adapter.sv
`timescale 1ns/1ps
module tb_sdram_width_adapter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic [31:0] app_wr_data = '0;
    logic [3:0]  app_wr_be_n = '1;
    logic        app_wr_next, app_wr_last;
    logic        wr_start = 1'b0, wr_take = 1'b0, wr_last = 1'b0;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be_n;
    logic        rd_start = 1'b0, rd_beat = 1'b0, rd_last = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] app_rd_data;
    logic        app_rd_valid, app_rd_last;

    always #10 clk = ~clk;

    sdram_width_adapter dut (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
        .app_wr_data(app_wr_data), .app_wr_be_n(app_wr_be_n),
        .app_wr_next(app_wr_next), .app_wr_last(app_wr_last),
        .wr_start(wr_start), .wr_take(wr_take), .wr_last(wr_last),
        .mem_wr_data(mem_wr_data), .mem_wr_be_n(mem_wr_be_n),
        .rd_start(rd_start), .rd_beat(rd_beat), .rd_last(rd_last),
        .mem_rd_data(mem_rd_data), .app_rd_data(app_rd_data),
        .app_rd_valid(app_rd_valid), .app_rd_last(app_rd_last)
    );

    typedef struct {
        logic [31:0] wd;
        logic [3:0]  wbe;
        logic        chk_w;
        logic        wn;
        logic        wl;
        logic        rv;
        logic        rl;
        logic [31:0] rd;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic [31:0] m_acc = '0;
    int          m_k = 0;

    function automatic int beats_of(input logic [1:0] w);
        if (w[1])      return 4;
        else if (w[0]) return 2;
        else           return 1;
    endfunction

    task automatic push(input exp_t e, input string tag);
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(posedge clk); #2;
        wr_start = 0; wr_take = 0; wr_last = 0;
        rd_start = 0; rd_beat = 0; rd_last = 0;
        e = '{default: '0};
        push(e, tag);
    endtask

    task automatic wr_beat(input logic [1:0] w, input logic [31:0] word, input logic [3:0] be,
                           input int k, input bit st, input bit lst, input string tag);
        exp_t e;
        int   n;
        @(posedge clk); #2;
        width_sel = w; app_wr_data = word; app_wr_be_n = be;
        wr_start = st; wr_take = 1; wr_last = lst;
        rd_start = 0; rd_beat = 0; rd_last = 0;
        n = beats_of(w);
        e = '{default: '0};
        e.chk_w = 1;
        if (n == 1) begin
            e.wd = word; e.wbe = be;
        end else if (n == 2) begin
            e.wd  = {16'h0, word[16*k +: 16]};
            e.wbe = {2'b11, be[2*k +: 2]};
        end else begin
            e.wd  = {24'h0, word[8*k +: 8]};
            e.wbe = {3'b111, be[k]};
        end
        e.wn = (k == n - 1) || lst;
        e.wl = e.wn && lst;
        push(e, tag);
    endtask

    task automatic rd_beat_t(input logic [1:0] w, input logic [31:0] beat,
                             input bit st, input bit lst, input string tag);
        exp_t e;
        int   n;
        @(posedge clk); #2;
        width_sel = w; mem_rd_data = beat;
        rd_start = st; rd_beat = 1; rd_last = lst;
        wr_start = 0; wr_take = 0; wr_last = 0;
        n = beats_of(w);
        if (st) begin m_k = 0; m_acc = '0; end
        if (n == 1)      m_acc = beat;
        else if (n == 2) m_acc[16*m_k +: 16] = beat[15:0];
        else             m_acc[8*m_k +: 8] = beat[7:0];
        e = '{default: '0};
        e.rv = (m_k == n - 1) || lst;
        e.rl = e.rv && lst;
        e.rd = m_acc;
        push(e, tag);
        if (e.rv) begin m_k = 0; m_acc = '0; end
        else      m_k = m_k + 1;
    endtask

    // Monitor: pops one expectation per driven cycle, at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (expq.size() > 0) begin
                exp_t  e;
                string t;
                bit    bad;
                e = expq.pop_front();
                t = tagq.pop_front();
                bad = (app_wr_next !== e.wn) || (app_wr_last !== e.wl) ||
                      (app_rd_valid !== e.rv) || (app_rd_last !== e.rl);
                if (e.chk_w && ((mem_wr_data !== e.wd) || (mem_wr_be_n !== e.wbe))) bad = 1;
                if (e.rv && (app_rd_data !== e.rd)) bad = 1;
                n_checks++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: actual wd=%h wbe=%b wn=%b wl=%b rv=%b rl=%b rd=%h expected wd=%h wbe=%b wn=%b wl=%b rv=%b rl=%b rd=%h",
                             t, mem_wr_data, mem_wr_be_n, app_wr_next, app_wr_last,
                             app_rd_valid, app_rd_last, app_rd_data,
                             e.wd, e.wbe, e.wn, e.wl, e.rv, e.rl, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle("R5 reset state");

        // R2: 32-bit write burst of three words
        wr_beat(2'b00, 32'hA1B2C3D4, 4'b0000, 0, 1, 0, "R2");
        wr_beat(2'b00, 32'h11223344, 4'b0101, 0, 0, 0, "R2");
        wr_beat(2'b00, 32'hDEADBEEF, 4'b1010, 0, 0, 1, "R6 R2");
        idle("R5 idle");

        // R3: 16-bit write, two words
        wr_beat(2'b01, 32'hCAFEF00D, 4'b0110, 0, 1, 0, "R3 low half");
        wr_beat(2'b01, 32'hCAFEF00D, 4'b0110, 1, 0, 0, "R3 high half");
        wr_beat(2'b01, 32'h01234567, 4'b1001, 0, 0, 0, "R3 low half");
        wr_beat(2'b01, 32'h01234567, 4'b1001, 1, 0, 1, "R6 R3");
        idle("R5 idle");

        // R4 / R1: 8-bit write with both 1x encodings
        for (int k = 0; k < 4; k++)
            wr_beat(2'b10, 32'h89ABCDEF, 4'b0110, k, k == 0, 0, "R4 R1 sel10");
        for (int k = 0; k < 4; k++)
            wr_beat(2'b11, 32'h76543210, 4'b1100, k, 0, k == 3, "R4 R1 sel11");
        idle("R5 idle");

        // R5 / R6: 8-bit burst ending after two beats
        wr_beat(2'b10, 32'h5566AA77, 4'b0000, 0, 1, 0, "R5");
        wr_beat(2'b10, 32'h5566AA77, 4'b0000, 1, 0, 1, "R6 early end");
        idle("R5 idle");

        // R7: restart mid-word
        wr_beat(2'b10, 32'h0BADC0DE, 4'b0000, 0, 1, 0, "R7 first");
        wr_beat(2'b10, 32'hFACE1234, 4'b0011, 0, 1, 0, "R7 restart");
        for (int k = 1; k < 4; k++)
            wr_beat(2'b10, 32'hFACE1234, 4'b0011, k, 0, k == 3, "R7");
        idle("R5 idle");

        // R8: 32-bit read
        rd_beat_t(2'b00, 32'h13579BDF, 1, 0, "R8");
        rd_beat_t(2'b00, 32'h2468ACE0, 0, 1, "R8 R13");
        idle("R13 idle");

        // R9: 16-bit read, two words
        rd_beat_t(2'b01, 32'hFFFF1111, 1, 0, "R9");
        rd_beat_t(2'b01, 32'hEEEE2222, 0, 0, "R9");
        rd_beat_t(2'b01, 32'h00003333, 0, 0, "R9");
        rd_beat_t(2'b01, 32'h00004444, 0, 1, "R9 R13");
        idle("R13 idle");

        // R10: 8-bit read, one word
        rd_beat_t(2'b10, 32'hFFFFFF0A, 1, 0, "R10");
        rd_beat_t(2'b10, 32'h0000000B, 0, 0, "R10");
        rd_beat_t(2'b10, 32'h1234560C, 0, 0, "R10");
        rd_beat_t(2'b10, 32'h0000000D, 0, 1, "R10 R13");
        idle("R13 idle");

        // R11: restart discards a partial word
        rd_beat_t(2'b11, 32'h000000AA, 1, 0, "R11 first");
        rd_beat_t(2'b11, 32'h00000011, 1, 0, "R11 restart");
        rd_beat_t(2'b11, 32'h00000022, 0, 0, "R11");
        rd_beat_t(2'b11, 32'h00000033, 0, 0, "R11");
        rd_beat_t(2'b11, 32'h00000044, 0, 1, "R11");
        idle("R13 idle");

        // R12: partial words at burst end
        rd_beat_t(2'b10, 32'h000000C1, 1, 0, "R12");
        rd_beat_t(2'b10, 32'h000000C2, 0, 0, "R12");
        rd_beat_t(2'b10, 32'hFFFFFFC3, 0, 1, "R12 byte");
        idle("R13 idle");
        rd_beat_t(2'b01, 32'hABCD9876, 1, 1, "R12 half");
        idle("R13 idle");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule